// File: doc/BRIEF.md
# Multi-Level Channel Current Alarm Engine

This block watches one measured channel value and compares it against a shared set of alarm limits, each given as a percentage of the channel's breaker rating. It keeps a 16-bit status word that a host reads and clears through a small write port. Four latching levels (over-limit high-high and high, under-limit low and low-low) must hold their condition for a programmable number of tick strobes before they latch. Once latched they stay set until software clears them, a global clear command arrives, or the level's limit is reprogrammed.

A load-state tracker uses the low-low limit. The load is declared running once the value has stayed above that limit for a programmable ON time. A latched OFF flag is raised when a running load then stays below the limit for a programmable OFF time. Two non-latching alarms (high and low) follow the value at once and release with a percentage hysteresis band. They are read-only.

The block has no measurement front end, no bus decoding and no channel scanning. A scanner instantiates or time-shares it per channel.

Top module: `chanAlarmEngine`

## Requirements
- R1: Latching bit 0 (value > high-high limit), bit 1 (value > high limit), bit 2 (value < low limit) and bit 3 (value < low-low limit) is set once its condition has held while its delay timer has counted its programmed number of ticks. It then stays set after the value returns to normal.
- R2: A level's delay timer counts tick strobes only while the condition holds. It restarts from zero whenever the condition drops, so a condition shorter than the delay never latches.
- R3: A write with a 0 in bit 0 to 4 clears that latching bit. A 1 never sets a bit. Writes have no effect on bits 8 and 9 or on reserved bits. The timer is not restarted by the write, so a condition that still holds latches again on the next clock.
- R4: A global clear pulse clears bits 0 to 4, the load-running state and every latching timer.
- R5: Any change to a level's percentage clears that level's bit and restarts its timer on the next clock. A change to the low-low percentage also clears the OFF bit and the load-running state.
- R6: A limit is breaker × percent / 100, truncated. A percentage of 0 disables that alarm: its bit reads 0 and its timer stays at zero.
- R7: Non-latching bit 8 sets on the clock after the value exceeds its limit. It clears only when the value falls below limit − limit × hysteresis / 100.
- R8: Non-latching bit 9 sets on the clock after the value drops below its limit. It clears only when the value rises above limit + limit × hysteresis / 100.
- R9: A hysteresis setting above 100 acts as 100.
- R10: The load is declared running after the value stays above the low-low limit for the ON time. Bit 4 is set only when a running load then stays below that limit for the OFF time, and it then stays latched.
- R11: Status bits 5 to 7 and 10 to 15 read 0, and the whole word is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | SAMPLE_W | Measured channel value |
| breakerIn | input | SAMPLE_W | Breaker rating in sample units |
| tickIn | input | 1 | Timer tick strobe |
| latchPctIn | input | 4×PCT_W | Latching percentages, index 0 high-high, 1 high, 2 low, 3 low-low |
| latchDlyIn | input | 4×TMR_W | Latching delays in ticks, same indexing |
| onDlyIn | input | TMR_W | Load ON qualification time in ticks |
| offDlyIn | input | TMR_W | Load OFF qualification time in ticks |
| nlHiPctIn | input | PCT_W | Non-latching high percentage |
| nlLoPctIn | input | PCT_W | Non-latching low percentage |
| hystPctIn | input | PCT_W | Non-latching hysteresis percentage |
| clearAllIn | input | 1 | Global clear of latching state |
| wrEnIn | input | 1 | Status write strobe |
| wrDataIn | input | 16 | Status write data |
| statusOut | output | 16 | Alarm status word |

## Verification
The assertions assume that configuration inputs, the sample and the write strobe change only between clock edges. They also assume that PCT_W is wide enough to hold 100, so the computed limits never wrap. The bench drives every input on the falling edge and keeps breaker ratings and percentages small, so limits and hysteresis bands stay far inside the datapath width. The per-cycle comparison relies on configuration changes being single, isolated steps, and the stimulus applies each one alone with settling time before the next.

// File: rtl/chanAlarmPkg.sv
package chanAlarmPkg;
  localparam int LVL_N    = 4;
  localparam int TMR_N    = 6;
  localparam int TMR_ON   = 4;
  localparam int TMR_OFF  = 5;
  localparam int LVL_LOLO = 3;
  localparam int STAT_W   = 16;
  localparam int BIT_OFF  = 4;
  localparam int BIT_NLHI = 8;
  localparam int BIT_NLLO = 9;

  // Strobes from control to datapath timers
  typedef struct packed {
    logic [TMR_N-1:0] cntClr;
    logic [TMR_N-1:0] cntInc;
  } tmrStrobe_t;

  // Compare results and timer status from datapath to control
  typedef struct packed {
    logic [LVL_N-1:0] lvlEn;
    logic [LVL_N-1:0] lvlHit;
    logic [LVL_N-1:0] lvlChg;
    logic [TMR_N-1:0] cntDone;
    logic             aboveLoLo;
    logic             belowLoLo;
    logic             nlHiEn;
    logic             nlHiSet;
    logic             nlHiRel;
    logic             nlLoEn;
    logic             nlLoSet;
    logic             nlLoRel;
  } dpFlags_t;
endpackage

// File: rtl/chanAlarmDatapath.sv
module chanAlarmDatapath
  import chanAlarmPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PCT_W    = 8,
  parameter int TMR_W    = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SAMPLE_W-1:0]           sampleIn,
  input  logic [SAMPLE_W-1:0]           breakerIn,
  input  logic [LVL_N-1:0][PCT_W-1:0]   latchPctIn,
  input  logic [LVL_N-1:0][TMR_W-1:0]   latchDlyIn,
  input  logic [TMR_W-1:0]              onDlyIn,
  input  logic [TMR_W-1:0]              offDlyIn,
  input  logic [PCT_W-1:0]              nlHiPctIn,
  input  logic [PCT_W-1:0]              nlLoPctIn,
  input  logic [PCT_W-1:0]              hystPctIn,
  input  tmrStrobe_t                    strobe,
  output dpFlags_t                      flags
);
  localparam int PROD_W = SAMPLE_W + PCT_W;
  localparam int HYS_W  = PROD_W + PCT_W;
  localparam logic [PROD_W-1:0] FULL_SCALE = PROD_W'(100);
  localparam logic [HYS_W-1:0]  FULL_HYS   = HYS_W'(100);
  localparam logic [PCT_W-1:0]  HYST_MAX   = PCT_W'(100);

  function automatic logic [PROD_W-1:0] pctOf(input logic [SAMPLE_W-1:0] base,
                                              input logic [PCT_W-1:0] pct);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(base) * PROD_W'(pct);
    return prod / FULL_SCALE;
  endfunction

  function automatic logic [PROD_W-1:0] marginOf(input logic [PROD_W-1:0] thr,
                                                 input logic [PCT_W-1:0] pct);
    logic [HYS_W-1:0] prod;
    prod = HYS_W'(thr) * HYS_W'(pct);
    return PROD_W'(prod / FULL_HYS);
  endfunction

  logic [PROD_W-1:0]              sampleX;
  logic [LVL_N-1:0][PROD_W-1:0]   lvlThr;
  logic [LVL_N-1:0][PCT_W-1:0]    pctPrev;
  logic [LVL_N-1:0]               lvlHit;
  logic [TMR_N-1:0][TMR_W-1:0]    tmrLim;
  logic [TMR_W-1:0]               tmrCnt [TMR_N];
  logic [TMR_N-1:0]               tmrDone;
  logic [PCT_W-1:0]               hystEff;
  logic [PROD_W-1:0]              nlHiThr, nlLoThr, nlHiMargin, nlLoMargin;

  assign sampleX = PROD_W'(sampleIn);
  assign tmrLim  = {offDlyIn, onDlyIn, latchDlyIn};
  assign hystEff = (hystPctIn > HYST_MAX) ? HYST_MAX : hystPctIn;

  // Per-level limits; the first half compare over, the second half under
  for (genvar k = 0; k < LVL_N; k++) begin : g_lvl
    assign lvlThr[k] = pctOf(breakerIn, latchPctIn[k]);
    if (k < LVL_N / 2) begin : g_over
      assign lvlHit[k] = sampleX > lvlThr[k];
    end else begin : g_under
      assign lvlHit[k] = sampleX < lvlThr[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pctPrev <= '0;
    else       pctPrev <= latchPctIn;
  end

  // Delay timers: saturate at their limit, cleared by control strobe
  for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        tmrCnt[t] <= '0;
      else if (strobe.cntClr[t])
        tmrCnt[t] <= '0;
      else if (strobe.cntInc[t] && (tmrCnt[t] < tmrLim[t]))
        tmrCnt[t] <= tmrCnt[t] + TMR_W'(1);
    end
  end

  always_comb begin
    for (int t = 0; t < TMR_N; t++) tmrDone[t] = tmrCnt[t] >= tmrLim[t];
  end

  assign nlHiThr    = pctOf(breakerIn, nlHiPctIn);
  assign nlLoThr    = pctOf(breakerIn, nlLoPctIn);
  assign nlHiMargin = marginOf(nlHiThr, hystEff);
  assign nlLoMargin = marginOf(nlLoThr, hystEff);

  always_comb begin
    flags           = '0;
    for (int k = 0; k < LVL_N; k++) begin
      flags.lvlEn[k]  = latchPctIn[k] != '0;
      flags.lvlChg[k] = latchPctIn[k] != pctPrev[k];
    end
    flags.lvlHit    = lvlHit;
    flags.cntDone   = tmrDone;
    flags.aboveLoLo = sampleX > lvlThr[LVL_LOLO];
    flags.belowLoLo = sampleX < lvlThr[LVL_LOLO];
    flags.nlHiEn    = nlHiPctIn != '0;
    flags.nlHiSet   = sampleX > nlHiThr;
    flags.nlHiRel   = sampleX < (nlHiThr - nlHiMargin);
    flags.nlLoEn    = nlLoPctIn != '0;
    flags.nlLoSet   = sampleX < nlLoThr;
    flags.nlLoRel   = sampleX > (nlLoThr + nlLoMargin);
  end
endmodule

// File: rtl/chanAlarmControl.sv
module chanAlarmControl
  import chanAlarmPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickIn,
  input  logic               clearAllIn,
  input  logic               wrEnIn,
  input  logic [BIT_OFF:0]   wrLowIn,
  input  dpFlags_t           flags,
  output tmrStrobe_t         strobe,
  output logic [STAT_W-1:0]  statusOut
);
  logic [LVL_N-1:0] latchQ;
  logic             onState;
  logic             offQ;
  logic             nlHiQ;
  logic             nlLoQ;
  logic [BIT_OFF:0] wrClr;
  logic             loloFlush;
  logic             offEvent;

  assign wrClr     = wrEnIn ? ~wrLowIn : '0;
  assign loloFlush = !flags.lvlEn[LVL_LOLO] || flags.lvlChg[LVL_LOLO] || clearAllIn;
  assign offEvent  = onState && flags.belowLoLo && flags.cntDone[TMR_OFF];

  always_comb begin
    strobe = '0;
    for (int k = 0; k < LVL_N; k++) begin
      strobe.cntClr[k] = !flags.lvlEn[k] || !flags.lvlHit[k] || flags.lvlChg[k] || clearAllIn;
      strobe.cntInc[k] = tickIn;
    end
    strobe.cntClr[TMR_ON]  = loloFlush || onState || !flags.aboveLoLo;
    strobe.cntClr[TMR_OFF] = loloFlush || !onState || !flags.belowLoLo;
    strobe.cntInc[TMR_ON]  = tickIn;
    strobe.cntInc[TMR_OFF] = tickIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ  <= '0;
      onState <= 1'b0;
      offQ    <= 1'b0;
      nlHiQ   <= 1'b0;
      nlLoQ   <= 1'b0;
    end else begin
      for (int k = 0; k < LVL_N; k++) begin
        if (!flags.lvlEn[k] || flags.lvlChg[k] || clearAllIn || wrClr[k])
          latchQ[k] <= 1'b0;
        else if (flags.lvlHit[k] && flags.cntDone[k])
          latchQ[k] <= 1'b1;
      end

      if (loloFlush)
        onState <= 1'b0;
      else if (!onState && flags.aboveLoLo && flags.cntDone[TMR_ON])
        onState <= 1'b1;
      else if (offEvent)
        onState <= 1'b0;

      if (loloFlush || wrClr[BIT_OFF]) offQ <= 1'b0;
      else if (offEvent)               offQ <= 1'b1;

      if (!flags.nlHiEn)       nlHiQ <= 1'b0;
      else if (flags.nlHiSet)  nlHiQ <= 1'b1;
      else if (flags.nlHiRel)  nlHiQ <= 1'b0;

      if (!flags.nlLoEn)       nlLoQ <= 1'b0;
      else if (flags.nlLoSet)  nlLoQ <= 1'b1;
      else if (flags.nlLoRel)  nlLoQ <= 1'b0;
    end
  end

  always_comb begin
    statusOut              = '0;
    statusOut[LVL_N-1:0]   = latchQ;
    statusOut[BIT_OFF]     = offQ;
    statusOut[BIT_NLHI]    = nlHiQ;
    statusOut[BIT_NLLO]    = nlLoQ;
  end
endmodule

// File: rtl/chanAlarmEngine.sv
module chanAlarmEngine
  import chanAlarmPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PCT_W    = 8,
  parameter int TMR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SAMPLE_W-1:0]         sampleIn,
  input  logic [SAMPLE_W-1:0]         breakerIn,
  input  logic                        tickIn,
  input  logic [LVL_N-1:0][PCT_W-1:0] latchPctIn,
  input  logic [LVL_N-1:0][TMR_W-1:0] latchDlyIn,
  input  logic [TMR_W-1:0]            onDlyIn,
  input  logic [TMR_W-1:0]            offDlyIn,
  input  logic [PCT_W-1:0]            nlHiPctIn,
  input  logic [PCT_W-1:0]            nlLoPctIn,
  input  logic [PCT_W-1:0]            hystPctIn,
  input  logic                        clearAllIn,
  input  logic                        wrEnIn,
  input  logic [STAT_W-1:0]           wrDataIn,
  output logic [STAT_W-1:0]           statusOut
);
  tmrStrobe_t strobe;
  dpFlags_t   flags;
  logic       unusedWrBits;

  // Only the latching bits take writes; the rest of the word is read-only
  assign unusedWrBits = ^wrDataIn[STAT_W-1:BIT_OFF+1];

  chanAlarmDatapath #(
    .SAMPLE_W(SAMPLE_W),
    .PCT_W   (PCT_W),
    .TMR_W   (TMR_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .breakerIn (breakerIn),
    .latchPctIn(latchPctIn),
    .latchDlyIn(latchDlyIn),
    .onDlyIn   (onDlyIn),
    .offDlyIn  (offDlyIn),
    .nlHiPctIn (nlHiPctIn),
    .nlLoPctIn (nlLoPctIn),
    .hystPctIn (hystPctIn),
    .strobe    (strobe),
    .flags     (flags)
  );

  chanAlarmControl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .clearAllIn(clearAllIn),
    .wrEnIn    (wrEnIn),
    .wrLowIn   (wrDataIn[BIT_OFF:0]),
    .flags     (flags),
    .strobe    (strobe),
    .statusOut (statusOut)
  );
endmodule

// File: rtl/chanAlarmChecker.sv
module chanAlarmChecker #(
  parameter int SAMPLE_W = 16,
  parameter int PCT_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic [SAMPLE_W-1:0] breakerIn,
  input logic [PCT_W-1:0]    hiPctIn,
  input logic [PCT_W-1:0]    loPctIn,
  input logic [PCT_W-1:0]    loloPctIn,
  input logic [PCT_W-1:0]    nlHiPctIn,
  input logic                clearAllIn,
  input logic                wrEnIn,
  input logic                wrBit0In,
  input logic [4:0]          latchStatIn,
  input logic                nlHiStatIn
);
  localparam int PROD_W = SAMPLE_W + PCT_W;

  function automatic logic [PROD_W-1:0] limitOf(input logic [SAMPLE_W-1:0] base,
                                                input logic [PCT_W-1:0] pct);
    return (PROD_W'(base) * PROD_W'(pct)) / PROD_W'(100);
  endfunction

  logic              armed;
  logic [PROD_W-1:0] sampleX, hiLim, loloLim, nlHiLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign sampleX = PROD_W'(sampleIn);
  assign hiLim   = limitOf(breakerIn, hiPctIn);
  assign loloLim = limitOf(breakerIn, loloPctIn);
  assign nlHiLim = limitOf(breakerIn, nlHiPctIn);

  // R1: the high latching bit only rises after the value exceeded its limit
  a_r1_hi_rise_needs_excess: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $rose(latchStatIn[1])) |-> $past(sampleX > hiLim));

  // R5: reprogramming the high level clears its bit on the next clock
  a_r5_pct_change_clears: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (hiPctIn != $past(hiPctIn))) |=> !latchStatIn[1]);

  // R3: writing 0 to bit 0 clears it
  a_r3_write_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnIn && !wrBit0In) |=> !latchStatIn[0]);

  // R4: global clear empties every latching bit
  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    clearAllIn |=> (latchStatIn == 5'b0));

  // R6: a zero percentage keeps the low level quiet
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (loPctIn == '0) |=> !latchStatIn[2]);

  // R7: the non-latching high alarm follows an excess on the next clock
  a_r7_nl_high_prompt: assert property (@(posedge clk) disable iff (!rstN)
    ((nlHiPctIn != '0) && (sampleX > nlHiLim)) |=> nlHiStatIn);

  // R10: the OFF flag only rises after the value was under the low-low limit
  a_r10_off_needs_drop: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $rose(latchStatIn[4])) |-> $past(sampleX < loloLim));
endmodule

bind chanAlarmEngine chanAlarmChecker #(
  .SAMPLE_W(SAMPLE_W),
  .PCT_W   (PCT_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sampleIn   (sampleIn),
  .breakerIn  (breakerIn),
  .hiPctIn    (latchPctIn[1]),
  .loPctIn    (latchPctIn[2]),
  .loloPctIn  (latchPctIn[3]),
  .nlHiPctIn  (nlHiPctIn),
  .clearAllIn (clearAllIn),
  .wrEnIn     (wrEnIn),
  .wrBit0In   (wrDataIn[0]),
  .latchStatIn(statusOut[4:0]),
  .nlHiStatIn (statusOut[8])
);

// File: tb/chanAlarmEngine_tb_top.sv
module chanAlarmEngine_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [15:0]      sample = '0;
  logic [15:0]      breaker = 16'd200;
  logic             tick = 1'b0;
  logic [3:0][7:0]  latchPct;
  logic [3:0][11:0] latchDly;
  logic [11:0]      onDly = 12'd3;
  logic [11:0]      offDly = 12'd2;
  logic [7:0]       nlHiPct = 8'd60;
  logic [7:0]       nlLoPct = 8'd30;
  logic [7:0]       hystPct = 8'd10;
  logic             clearAll = 1'b0;
  logic             wrEn = 1'b0;
  logic [15:0]      wrData = '0;
  logic [15:0]      status;

  int errCnt = 0;
  int chkCnt = 0;
  bit benchDone = 1'b0;
  int tickDiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chanAlarmEngine dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sample),
    .breakerIn (breaker),
    .tickIn    (tick),
    .latchPctIn(latchPct),
    .latchDlyIn(latchDly),
    .onDlyIn   (onDly),
    .offDlyIn  (offDly),
    .nlHiPctIn (nlHiPct),
    .nlLoPctIn (nlLoPct),
    .hystPctIn (hystPct),
    .clearAllIn(clearAll),
    .wrEnIn    (wrEn),
    .wrDataIn  (wrData),
    .statusOut (status)
  );

  // Tick strobe on every third cycle
  always @(negedge clk) begin
    if (tickDiv == 2) begin tickDiv <= 0; tick <= 1'b1; end
    else begin tickDiv <= tickDiv + 1; tick <= 1'b0; end
  end

  // ---------------- behavioural reference model ----------------
  int mCnt [6];
  bit mLat [4];
  int mPrev [4];
  bit mOn, mOff, mHi, mLo;

  function automatic int limitOf(int base, int pct);
    return (base * pct) / 100;
  endfunction

  function automatic logic [15:0] modelWord();
    logic [15:0] w;
    w = '0;
    for (int k = 0; k < 4; k++) w[k] = mLat[k];
    w[4] = mOff;
    w[8] = mHi;
    w[9] = mLo;
    return w;
  endfunction

  always @(posedge clk or negedge rstN) begin : m_step
    int s, lim, h, hiThr, loThr;
    int thr [4];
    int nCnt [6];
    bit nLat [4];
    bit en [4], hit [4], chg [4];
    bit above, below, flush, offEv, nOn, nOff, nHi, nLo;
    if (!rstN) begin
      for (int k = 0; k < 6; k++) mCnt[k] = 0;
      for (int k = 0; k < 4; k++) begin mLat[k] = 0; mPrev[k] = 0; end
      mOn = 0; mOff = 0; mHi = 0; mLo = 0;
    end else begin
      s = int'(sample);
      for (int k = 0; k < 4; k++) begin
        thr[k] = limitOf(int'(breaker), int'(latchPct[k]));
        en[k]  = latchPct[k] != 0;
        hit[k] = (k < 2) ? (s > thr[k]) : (s < thr[k]);
        chg[k] = int'(latchPct[k]) != mPrev[k];
        lim    = int'(latchDly[k]);
        if (!en[k] || chg[k] || clearAll || (wrEn && !wrData[k])) nLat[k] = 0;
        else if (hit[k] && mCnt[k] >= lim)                         nLat[k] = 1;
        else                                                       nLat[k] = mLat[k];
        if (!en[k] || !hit[k] || chg[k] || clearAll) nCnt[k] = 0;
        else if (tick && mCnt[k] < lim)               nCnt[k] = mCnt[k] + 1;
        else                                          nCnt[k] = mCnt[k];
      end
      above = s > thr[3];
      below = s < thr[3];
      flush = !en[3] || chg[3] || clearAll;
      offEv = mOn && below && (mCnt[5] >= int'(offDly));
      if (flush || mOn || !above)           nCnt[4] = 0;
      else if (tick && mCnt[4] < int'(onDly)) nCnt[4] = mCnt[4] + 1;
      else                                  nCnt[4] = mCnt[4];
      if (flush || !mOn || !below)           nCnt[5] = 0;
      else if (tick && mCnt[5] < int'(offDly)) nCnt[5] = mCnt[5] + 1;
      else                                   nCnt[5] = mCnt[5];
      if (flush)                                            nOn = 0;
      else if (!mOn && above && mCnt[4] >= int'(onDly))     nOn = 1;
      else if (offEv)                                       nOn = 0;
      else                                                  nOn = mOn;
      if (flush || (wrEn && !wrData[4])) nOff = 0;
      else if (offEv)                    nOff = 1;
      else                               nOff = mOff;
      h     = (hystPct > 100) ? 100 : int'(hystPct);
      hiThr = limitOf(int'(breaker), int'(nlHiPct));
      loThr = limitOf(int'(breaker), int'(nlLoPct));
      if (nlHiPct == 0)                    nHi = 0;
      else if (s > hiThr)                  nHi = 1;
      else if (s < hiThr - hiThr * h / 100) nHi = 0;
      else                                 nHi = mHi;
      if (nlLoPct == 0)                    nLo = 0;
      else if (s < loThr)                  nLo = 1;
      else if (s > loThr + loThr * h / 100) nLo = 0;
      else                                 nLo = mLo;
      for (int k = 0; k < 6; k++) mCnt[k] = nCnt[k];
      for (int k = 0; k < 4; k++) begin mLat[k] = nLat[k]; mPrev[k] = int'(latchPct[k]); end
      mOn = nOn; mOff = nOff; mHi = nHi; mLo = nLo;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !benchDone) begin
      chkCnt++;
      if (status !== modelWord()) begin
        errCnt++;
        $display("FAIL R11 per-cycle model at %0t: actual=%h expected=%h",
                 $time, status, modelWord());
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] mask, input logic [15:0] exp);
    chkCnt++;
    if ((status & mask) !== (exp & mask)) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, status & mask, exp & mask);
    end
  endtask

  task automatic writeStatus(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    step(1);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseClear();
    clearAll = 1'b1;
    step(1);
    clearAll = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!benchDone) begin
      benchDone = 1'b1;
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    latchPct[0] = 8'd90; latchPct[1] = 8'd75; latchPct[2] = 8'd20; latchPct[3] = 8'd10;
    latchDly[0] = 12'd3; latchDly[1] = 12'd5; latchDly[2] = 12'd4; latchDly[3] = 12'd2;
    sample = 16'd100;
    step(3);
    rstN = 1'b1;
    chk("R11 reset word", 16'hFFFF, 16'h0000);
    step(40);
    chk("R11 quiet in band", 16'hFFFF, 16'h0000);

    // Non-latching high with hysteresis (limit 120, release below 108)
    sample = 16'd130; step(1);
    chk("R7 high sets next clock", 16'hFFFF, 16'h0100);
    sample = 16'd115; step(5);
    chk("R7 held inside band", 16'hFFFF, 16'h0100);
    sample = 16'd105; step(1);
    chk("R7 released below band", 16'hFFFF, 16'h0000);

    // Short excursion over high limit (150) must not latch
    sample = 16'd160; step(1);
    sample = 16'd100; step(20);
    chk("R2 short excursion ignored", 16'hFFFF, 16'h0000);

    sample = 16'd160; step(40);
    chk("R1 high latches", 16'hFFFF, 16'h0102);
    sample = 16'd100; step(5);
    chk("R1 high stays latched", 16'hFFFF, 16'h0002);

    writeStatus(16'hFFFF);
    chk("R3 ones do not set or clear", 16'hFFFF, 16'h0002);
    writeStatus(16'hFFFD);
    chk("R3 zero clears bit1", 16'hFFFF, 16'h0000);

    // High-high (limit 180)
    sample = 16'd190; step(40);
    chk("R1 high-high latches", 16'hFFFF, 16'h0103);
    sample = 16'd100; step(5);
    chk("R1 both latched", 16'hFFFF, 16'h0003);
    latchPct[0] = 8'd95; step(2);
    chk("R5 limit change clears bit0", 16'hFFFF, 16'h0002);
    pulseClear();
    chk("R4 global clear", 16'hFFFF, 16'h0000);

    // Disabled high level
    latchPct[1] = 8'd0;
    sample = 16'd160; step(40);
    chk("R6 zero percent disables", 16'hFFFF, 16'h0100);
    sample = 16'd100; latchPct[1] = 8'd75; step(40);
    chk("R6 re-enabled quiet", 16'hFFFF, 16'h0000);

    // Non-latching low (limit 60, release above 66)
    sample = 16'd50; step(1);
    chk("R8 low sets next clock", 16'hFFFF, 16'h0200);
    sample = 16'd64; step(5);
    chk("R8 held inside band", 16'hFFFF, 16'h0200);
    sample = 16'd35; step(40);
    chk("R1 low latches", 16'hFFFF, 16'h0204);
    sample = 16'd10; step(40);
    chk("R10 OFF after ON", 16'hFFFF, 16'h021C);
    sample = 16'd100; step(5);
    chk("R8 released above band", 16'hFFFF, 16'h001C);
    writeStatus(16'hFFEF);
    chk("R3 zero clears OFF bit", 16'hFFFF, 16'h000C);
    writeStatus(16'h0000);
    chk("R3 all latching cleared", 16'hFFFF, 16'h0000);

    // OFF requires a prior ON declaration
    pulseClear();
    sample = 16'd10; step(40);
    chk("R10 no OFF without ON", 16'hFFFF, 16'h020C);
    writeStatus(16'h0000);
    chk("R3 non-latching unaffected by write", 16'hFFFF, 16'h0200);
    step(2);
    chk("R3 relatches while condition holds", 16'hFFFF, 16'h020C);

    // Hysteresis clamp: 200 acts as 100, so release needs value below 0
    hystPct = 8'd200;
    sample = 16'd130; step(2);
    sample = 16'd0; step(5);
    chk("R9 hysteresis clamped", 16'h0100, 16'h0100);
    nlHiPct = 8'd0;
    sample = 16'd130; step(5);
    chk("R6 non-latching disabled", 16'h0100, 16'h0000);

    benchDone = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule